// File: doc/BRIEF.md
# Chipset control register file

This block is the control and status register file of a system chipset. A processor-side port reaches it with byte, halfword or word reads and writes. It decodes a 14-bit offset window and holds three groups of state. The first is the system configuration word. The second covers the DMA address-translation base and limit, the three write-only I/O cache controls (physical tag, logical tag and buffer window) and a cache byte-mask word. The third holds fifteen remote-speed words and a descriptor array of eight DMA channels with four words each. The block performs no DMA transfers or cache actions. It only stores and presents the values that the neighbouring logic uses.

A narrow read picks one lane out of the aligned 32-bit word and returns it right-justified and zero-extended. A narrow write merges the new lane into the current aligned word in the same cycle and writes the whole word back. The port has no back-pressure. A write completes in the cycle its strobe is high. A read returns its data with `rd_valid` one clock later. The byte-mask word gathers bits across writes and empties itself once it has been read while completely full.

Top module: `ccr_regfile`

## Requirements
- R1: After reset the configuration word reads 0x00000104, offset 0x210 reads 0x00018186, offsets 0x220 and 0x238 read 7, each remote-speed word reads 7, and every other register reads 0.
- R2: Only address bits [13:0] take part in decoding, and bits [1:0] do not affect which register is selected, so 0x4018 and 0x8000001B select the same register as 0x018.
- R3: `rd_valid` is high exactly one clock after a cycle with `rd_en` high and `wr_en` low, and `rd_data` then holds the result. When `wr_en` and `rd_en` are both high, the write is performed and no read result is produced.
- R4: With `size` = 0 (byte), a read returns bits [8a+7:8a] of the aligned word in `rd_data[7:0]`, where a = addr[1:0], and the upper bits are zero.
- R5: With `size` = 1 (halfword), a read returns the upper half of the aligned word when addr[1] is 1 and the lower half otherwise, in `rd_data[15:0]`, with the upper bits zero. A `size` of 2 or 3 is a full word access.
- R6: A byte write replaces only the byte lane addr[1:0] of the aligned word with `wr_data[7:0]`. A halfword write replaces only the half selected by addr[1] with `wr_data[15:0]`. All other bits keep their values.
- R7: The fifteen remote-speed words sit at offsets 0x70 + 8k for k = 0..14. Offsets between them, such as 0x74, are unmapped.
- R8: DMA descriptor word r of channel c sits at offset 0x100 + 32c + 8r for c = 0..7 and r = 0..3, and every such word holds its own value.
- R9: A write to the byte-mask register at 0x58 ORs the merged write word into its current value, so a write never clears a bit.
- R10: A read of 0x58, of any size, that finds the word equal to 0xFFFFFFFF returns that value and then clears the register to 0.
- R11: Unmapped offsets read 0. Writes to unmapped offsets and to the read-only offsets 0x010, 0x038, 0x040, 0x208, 0x220 and 0x238 change nothing.
- R12: The physical tag (0x48), logical tag (0x50) and buffer window (0x60) are write-only. They drive `cache_ptag`, `cache_ltag` and `cache_window`, and a read of them returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Byte address; only bits [13:0] are decoded |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| wr_en | input | 1 | Write strobe; takes priority over `rd_en` |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data, right-justified for narrow writes |
| rd_data | output | 32 | Read result, right-justified and zero-extended |
| rd_valid | output | 1 | `rd_data` holds a new read result |
| cache_ptag | output | 32 | Write-only I/O cache physical tag |
| cache_ltag | output | 32 | Write-only I/O cache logical tag |
| cache_window | output | 32 | Write-only I/O cache buffer window |

## Verification
Word writes followed by reads at every lane and half position show whether lanes are extracted correctly. Byte and halfword writes into words that hold distinct patterns expose merges that clobber neighbouring lanes. The speed and descriptor arrays are filled with index-dependent values and read back in full, which catches aliased or misdecoded entries. The gap offsets, aliased high address bits and the read-only words separate the correct decode from one that is too loose. The byte-mask word is built up over several partial writes until it is full and then read twice, which separates OR accumulation from overwriting and checks that the clear happens only after a read that finds the word full.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [4:0] {
    K_NONE, K_CFG, K_INV, K_TLBASE, K_TLLIM, K_RFAIL, K_MFAIL,
    K_PTAG, K_LTAG, K_BMASK, K_WIN, K_SPEED, K_DMA,
    K_R208, K_R210, K_NVP, K_R238
  } reg_kind_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int OFS_CFG    = 'h000;
  localparam int OFS_INV    = 'h010;
  localparam int OFS_TLBASE = 'h018;
  localparam int OFS_TLLIM  = 'h020;
  localparam int OFS_RFAIL  = 'h038;
  localparam int OFS_MFAIL  = 'h040;
  localparam int OFS_PTAG   = 'h048;
  localparam int OFS_LTAG   = 'h050;
  localparam int OFS_BMASK  = 'h058;
  localparam int OFS_WIN    = 'h060;
  localparam int OFS_SPEED  = 'h070;
  localparam int OFS_DMA    = 'h100;
  localparam int OFS_R208   = 'h208;
  localparam int OFS_R210   = 'h210;
  localparam int OFS_NVP    = 'h220;
  localparam int OFS_R238   = 'h238;
  localparam int ARRAY_STRIDE = 8;

  localparam logic [31:0] RST_CFG   = 32'h0000_0104;
  localparam logic [31:0] RST_R210  = 32'h0001_8186;
  localparam logic [31:0] RST_SPEED = 32'd7;
  localparam logic [31:0] VAL_NVP   = 32'd7;
  localparam logic [31:0] VAL_R238  = 32'd7;
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int DEC_W         = 14,
  parameter int N_SPEED       = 15,
  parameter int N_CHAN        = 8,
  parameter int REGS_PER_CHAN = 4,
  parameter int IDX_W         = 5
) (
  input  logic [DEC_W-3:0] word_ofs,
  output reg_kind_t        kind,
  output logic [IDX_W-1:0] idx
);
  localparam int STEP_W  = ARRAY_STRIDE / 4;
  localparam int SPD_W0  = OFS_SPEED / 4;
  localparam int SPD_WN  = SPD_W0 + STEP_W * N_SPEED;
  localparam int DMA_W0  = OFS_DMA / 4;
  localparam int DMA_WN  = DMA_W0 + STEP_W * N_CHAN * REGS_PER_CHAN;

  always_comb begin
    int wi;
    wi   = int'(word_ofs);
    kind = K_NONE;
    idx  = '0;
    if (wi >= SPD_W0 && wi < SPD_WN && (wi % STEP_W) == 0) begin
      kind = K_SPEED;
      idx  = IDX_W'((wi - SPD_W0) / STEP_W);
    end else if (wi >= DMA_W0 && wi < DMA_WN && (wi % STEP_W) == 0) begin
      kind = K_DMA;
      idx  = IDX_W'((wi - DMA_W0) / STEP_W);
    end else begin
      case (wi)
        OFS_CFG    / 4: kind = K_CFG;
        OFS_INV    / 4: kind = K_INV;
        OFS_TLBASE / 4: kind = K_TLBASE;
        OFS_TLLIM  / 4: kind = K_TLLIM;
        OFS_RFAIL  / 4: kind = K_RFAIL;
        OFS_MFAIL  / 4: kind = K_MFAIL;
        OFS_PTAG   / 4: kind = K_PTAG;
        OFS_LTAG   / 4: kind = K_LTAG;
        OFS_BMASK  / 4: kind = K_BMASK;
        OFS_WIN    / 4: kind = K_WIN;
        OFS_R208   / 4: kind = K_R208;
        OFS_R210   / 4: kind = K_R210;
        OFS_NVP    / 4: kind = K_NVP;
        OFS_R238   / 4: kind = K_R238;
        default:        kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ccr_lanes.sv
module ccr_lanes
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_lane,
  output logic [DATA_W-1:0] merged
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] BYTE_M = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] HALF_M = DATA_W'(16'hFFFF);

  logic [SH_W-1:0] sh;

  always_comb begin
    sh = '0;
    if (size == SZ_BYTE) begin
      sh      = SH_W'({lane, 3'b000});
      rd_lane = (word_in >> sh) & BYTE_M;
      merged  = (word_in & ~(BYTE_M << sh)) | ((wdata & BYTE_M) << sh);
    end else if (size == SZ_HALF) begin
      sh      = SH_W'({lane[1], 4'b0000});
      rd_lane = (word_in >> sh) & HALF_M;
      merged  = (word_in & ~(HALF_M << sh)) | ((wdata & HALF_M) << sh);
    end else begin
      rd_lane = word_in;
      merged  = wdata;
    end
  end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int DEC_W         = 14,
  parameter int N_SPEED       = 15,
  parameter int N_CHAN        = 8,
  parameter int REGS_PER_CHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] cache_ptag,
  output logic [DATA_W-1:0] cache_ltag,
  output logic [DATA_W-1:0] cache_window
);
  localparam int N_DMA  = N_CHAN * REGS_PER_CHAN;
  localparam int IDX_W  = (N_DMA > N_SPEED) ? $clog2(N_DMA) : $clog2(N_SPEED);
  localparam int SPD_IW = $clog2(N_SPEED);
  localparam int DMA_IW = $clog2(N_DMA);

  logic              unused_hi_bits;
  reg_kind_t         kind;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cur_word, rd_lane, wr_word;
  logic              do_wr, do_rd;

  logic [DATA_W-1:0] cfg_q, tlbase_q, tllim_q, bmask_q, r210_q;
  logic [DATA_W-1:0] speed_q [N_SPEED];
  logic [DATA_W-1:0] dma_q   [N_DMA];

  assign unused_hi_bits = ^addr[ADDR_W-1:DEC_W];
  assign do_wr = wr_en;
  assign do_rd = rd_en & ~wr_en;

  ccr_decode #(
    .DEC_W(DEC_W), .N_SPEED(N_SPEED), .N_CHAN(N_CHAN),
    .REGS_PER_CHAN(REGS_PER_CHAN), .IDX_W(IDX_W)
  ) u_decode (
    .word_ofs(addr[DEC_W-1:2]),
    .kind    (kind),
    .idx     (idx)
  );

  always_comb begin
    case (kind)
      K_CFG:    cur_word = cfg_q;
      K_TLBASE: cur_word = tlbase_q;
      K_TLLIM:  cur_word = tllim_q;
      K_BMASK:  cur_word = bmask_q;
      K_SPEED:  cur_word = speed_q[idx[SPD_IW-1:0]];
      K_DMA:    cur_word = dma_q[idx[DMA_IW-1:0]];
      K_R210:   cur_word = r210_q;
      K_NVP:    cur_word = VAL_NVP;
      K_R238:   cur_word = VAL_R238;
      default:  cur_word = '0;
    endcase
  end

  ccr_lanes #(.DATA_W(DATA_W)) u_lanes (
    .word_in(cur_word),
    .lane   (addr[1:0]),
    .size   (size),
    .wdata  (wr_data),
    .rd_lane(rd_lane),
    .merged (wr_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= RST_CFG;
      tlbase_q     <= '0;
      tllim_q      <= '0;
      r210_q       <= RST_R210;
      cache_ptag   <= '0;
      cache_ltag   <= '0;
      cache_window <= '0;
    end else if (do_wr) begin
      case (kind)
        K_CFG:    cfg_q        <= wr_word;
        K_TLBASE: tlbase_q     <= wr_word;
        K_TLLIM:  tllim_q      <= wr_word;
        K_R210:   r210_q       <= wr_word;
        K_PTAG:   cache_ptag   <= wr_word;
        K_LTAG:   cache_ltag   <= wr_word;
        K_WIN:    cache_window <= wr_word;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bmask_q <= '0;
    end else if (do_wr && kind == K_BMASK) begin
      bmask_q <= bmask_q | wr_word;
    end else if (do_rd && kind == K_BMASK && bmask_q == '1) begin
      bmask_q <= '0;
    end
  end

  for (genvar gs = 0; gs < N_SPEED; gs++) begin : g_speed
    always_ff @(posedge clk) begin
      if (!rst_n)
        speed_q[gs] <= RST_SPEED;
      else if (do_wr && kind == K_SPEED && int'(idx) == gs)
        speed_q[gs] <= wr_word;
    end
  end

  for (genvar gd = 0; gd < N_DMA; gd++) begin : g_dma
    always_ff @(posedge clk) begin
      if (!rst_n)
        dma_q[gd] <= '0;
      else if (do_wr && kind == K_DMA && int'(idx) == gd)
        dma_q[gd] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_lane;
    end
  end

  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);
  a_r3_no_valid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> !rd_valid);
  a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && size == SZ_BYTE) |=> (rd_data[DATA_W-1:8] == '0));
  a_r5_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && size == SZ_HALF) |=> (rd_data[DATA_W-1:16] == '0));
  a_r9_mask_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_BMASK) |=> ((bmask_q & $past(bmask_q)) == $past(bmask_q)));
  a_r10_mask_clears_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && kind == K_BMASK && bmask_q == '1) |=> (bmask_q == '0));
  a_r11_readonly_cfg_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && kind == K_CFG) |=> $stable(cfg_q));
endmodule

// File: tb/ccr_regfile_tb.sv
`timescale 1ns/1ps
module ccr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = 2'd2;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, cache_ptag, cache_ltag, cache_window;
  logic        rd_valid;

  int checks = 0, fails = 0;
  logic [31:0] mm [int];
  logic [31:0] m_ptag, m_ltag, m_win;

  always #2 clk = ~clk;

  ccr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .cache_ptag(cache_ptag), .cache_ltag(cache_ltag), .cache_window(cache_window)
  );

  // 0 unmapped, 1 read/write, 2 write-only, 3 byte mask, 4 reads 0, 5 reads 7
  function automatic int kind_of(int o);
    if (o == 'h0 || o == 'h18 || o == 'h20 || o == 'h210) return 1;
    if (o >= 'h70 && o <= 'he0 && o % 8 == 0) return 1;
    if (o >= 'h100 && o < 'h200 && o % 8 == 0) return 1;
    if (o == 'h48 || o == 'h50 || o == 'h60) return 2;
    if (o == 'h58) return 3;
    if (o == 'h10 || o == 'h38 || o == 'h40 || o == 'h208) return 4;
    if (o == 'h220 || o == 'h238) return 5;
    return 0;
  endfunction

  function automatic logic [31:0] mread(int o);
    int k = kind_of(o);
    if (k == 1 || k == 3) return mm.exists(o) ? mm[o] : 32'h0;
    if (k == 5) return 32'd7;
    return 32'h0;
  endfunction

  task automatic model_reset();
    mm.delete();
    mm['h0] = 32'h104;
    mm['h210] = 32'h18186;
    for (int k = 0; k < 15; k++) mm['h70 + 8*k] = 32'd7;
    m_ptag = 0; m_ltag = 0; m_win = 0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle, checks at the next falling edge.
  task automatic op(input bit w, input bit r, input logic [31:0] a,
                    input logic [1:0] sz, input logic [31:0] d, input string tag);
    int o = int'(a & 32'h3FFC);
    int ln = int'(a[1:0]);
    logic [31:0] v, nv, exp;
    bit expv = r && !w;
    addr = a; size = sz; wr_en = w; rd_en = r; wr_data = d;
    v = mread(o);
    exp = 0;
    if (w) begin
      nv = v;
      if (sz == 0) nv[8*ln +: 8] = d[7:0];
      else if (sz == 1) begin
        if (a[1]) nv[31:16] = d[15:0]; else nv[15:0] = d[15:0];
      end else nv = d;
      case (kind_of(o))
        1: mm[o] = nv;
        3: mm[o] = v | nv;
        2: if (o == 'h48) m_ptag = nv; else if (o == 'h50) m_ltag = nv; else m_win = nv;
        default: ;
      endcase
    end else if (r) begin
      if (sz == 0) exp = (v >> (8*ln)) & 32'hFF;
      else if (sz == 1) exp = a[1] ? (v >> 16) : (v & 32'hFFFF);
      else exp = v;
      if (kind_of(o) == 3 && v == 32'hFFFF_FFFF) mm[o] = 0;
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check({tag, " valid"}, {31'b0, rd_valid}, {31'b0, expv});
    if (expv) check({tag, " data"}, rd_data, exp);
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input string tag);
    op(0, 1, a, sz, 0, tag);
  endtask
  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    op(1, 0, a, sz, d, tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    op(0, 0, 0, 2, 0, "R3 idle");
    // R1 reset values
    rd('h000, 2, "R1 cfg");
    rd('h210, 2, "R1 r210");
    rd('h220, 2, "R1 nvp");
    rd('h238, 2, "R1 r238");
    rd('h018, 2, "R1 tlbase");
    rd('h058, 2, "R1 bmask");
    rd('h010, 2, "R1 inv");
    for (int k = 0; k < 15; k++) rd('h70 + 8*k, 2, "R1 R7 speed reset");
    rd('h100, 2, "R1 dma");
    check("R1 ptag out", cache_ptag, 0);
    // R2 decode window and alignment
    wr('h000, 2, 32'hDEAD_BEEF, "R2 cfg write");
    rd('h4000, 2, "R2 alias 0x4000");
    rd('h8000_0003, 2, "R2 high bits and offset 3");
    wr('hC000_401A, 2, 32'h1234_5678, "R2 aliased write");
    rd('h018, 2, "R2 tlbase readback");
    // R4 byte lanes, R5 halves
    for (int l = 0; l < 4; l++) rd(l, 0, "R4 byte lane");
    for (int l = 0; l < 4; l++) rd(l, 1, "R5 half");
    rd('h003, 3, "R5 size3 word");
    // R6 narrow writes
    wr('h020, 2, 32'h1122_3344, "R6 prep");
    wr('h022, 0, 32'hFFFF_FFA5, "R6 byte lane2");
    rd('h020, 2, "R6 byte merge");
    wr('h021, 0, 32'h0000_005A, "R6 byte lane1");
    rd('h020, 2, "R6 byte merge2");
    wr('h01B, 1, 32'hABCD_9876, "R6 upper half");
    rd('h018, 2, "R6 half merge");
    wr('h210, 1, 32'h0000_CAFE, "R6 lower half");
    rd('h210, 2, "R6 half merge low");
    // R7 speed array
    for (int k = 0; k < 15; k++) wr('h70 + 8*k, 2, 32'h100 + k, "R7 fill");
    for (int k = 0; k < 15; k++) rd('h70 + 8*k, 2, "R7 readback");
    wr('h074, 2, 32'h5555_5555, "R7 gap write");
    rd('h074, 2, "R7 gap read");
    rd('h0E8, 2, "R7 past end");
    // R8 DMA array
    for (int k = 0; k < 32; k++) wr('h100 + 8*k, 2, 32'hA000_0000 | (k * 32'h0101), "R8 fill");
    for (int k = 0; k < 32; k++) rd('h100 + 8*k, 2, "R8 readback");
    rd('h104, 2, "R8 gap");
    // R9 byte mask accumulation
    wr('h058, 2, 32'h0F0F_0F0F, "R9 first");
    wr('h058, 2, 32'h00FF_0000, "R9 second");
    rd('h058, 2, "R9 accumulate");
    rd('h058, 2, "R9 no clear when partial");
    wr('h05B, 0, 32'h0000_00F0, "R9 byte or");
    rd('h058, 2, "R9 byte or readback");
    // R10 clear on full read
    wr('h058, 2, 32'hF0F0_F0F0, "R10 fill");
    rd('h058, 2, "R10 full read");
    rd('h058, 2, "R10 cleared");
    wr('h058, 2, 32'hFFFF_FFFF, "R10 refill");
    rd('h059, 0, "R10 byte read of full");
    rd('h058, 2, "R10 cleared by byte read");
    // R11 unmapped and read-only
    wr('h220, 2, 32'h0, "R11 ro write");
    rd('h220, 2, "R11 ro kept");
    wr('h010, 2, 32'hFFFF_FFFF, "R11 ro inv write");
    rd('h010, 2, "R11 inv zero");
    wr('h300, 2, 32'h1234, "R11 unmapped write");
    rd('h300, 2, "R11 unmapped read");
    rd('h3FFC, 2, "R11 top of window");
    rd('h000, 2, "R11 cfg untouched");
    // R12 write-only cache controls
    wr('h048, 2, 32'h8000_0001, "R12 ptag");
    wr('h050, 2, 32'h0BAD_F00D, "R12 ltag");
    wr('h060, 2, 32'h0000_0042, "R12 window");
    check("R12 ptag out", cache_ptag, m_ptag);
    check("R12 ltag out", cache_ltag, m_ltag);
    check("R12 window out", cache_window, m_win);
    rd('h048, 2, "R12 ptag reads zero");
    rd('h060, 2, "R12 window reads zero");
    // R3 write priority and back-to-back reads
    op(1, 1, 'h018, 2, 32'h0000_0055, "R3 both strobes");
    rd('h018, 2, "R3 write happened");
    rd('h020, 2, "R3 back to back");
    op(0, 0, 0, 2, 0, "R3 idle after");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule